// File: doc/BRIEF.md
# Clock power-down sequencer

This block controls the ordered shutdown and cold restart of a clock synthesizer. It takes an asynchronous, active-low power-down request and passes it through a two-flop synchronizer on the reference clock. It parks every output clock low and holds it there. Only after that does it disable the synthesizer VCOs, and after them the crystal oscillator. While power-down is in effect, the CPU-group and PCI-group stop requests have no effect.

On release, the oscillator enable returns at once through an asynchronous clear, so the wake-up path does not depend on a running reference clock. The sequencer waits a programmable oscillator settle count and then re-enables the VCOs. It waits for the lock input and then a programmable lock settle count. It lets the clocks toggle again only at a low-phase boundary, so that the first high pulse of each output is full width.

In normal running, each output has its own gate enable. The two stop inputs clear the enables of their groups. The analog loop and the crystal are outside the block: they appear only as the enable outputs, the lock input and a phase marker.

Top module: `clkpd_sequencer`

## Requirements
- R1: While the synchronous reset is held, the outputs are run_status=1, vco_en=1, osc_en=1 and clk_en all zero.
- R2: While running, each bit i of clk_en equals NOT(cpu_stop_n=0 AND CPU_MASK[i]) AND NOT(pci_stop_n=0 AND PCI_MASK[i]). The default bit order is 0 CPU, 1 PCI, 2 free-running PCI, 3 48 MHz, 4 reference, so CPU_MASK=5'b00001 and PCI_MASK=5'b00010.
- R3: clk_en changes only at a rising reference edge at which phase_low is 1.
- R4: The power-down request acts only through a two-flop synchronizer. run_status stays 1 one cycle after the request and falls within four cycles.
- R5: Outside the running state, all clk_en bits are driven and held at 0, and the stop inputs have no effect on them.
- R6: vco_en is low only while every clk_en bit is 0.
- R7: osc_en is low only while vco_en is low, and it falls only after vco_en has fallen.
- R8: A rising edge on pwrdn_req_n returns osc_en to 1 immediately, even with no reference clock running.
- R9: After release, vco_en stays low for OSC_START_CYC cycles and rises between OSC_START_CYC+2 and OSC_START_CYC+6 cycles after the reference clock runs.
- R10: run_status returns to 1 only after vco_lock has been high for LOCK_SETTLE_CYC cycles. After that, clk_en returns to its running value.
- R11: A power-down request during the wake-up wait sends the sequencer back down (VCOs off, then oscillator off) without ever releasing the clocks. A later release completes a full wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwrdn_req_n | input | 1 | Asynchronous power-down request, active low |
| cpu_stop_n | input | 1 | CPU-group stop request, active low |
| pci_stop_n | input | 1 | PCI-group stop request, active low |
| vco_lock | input | 1 | Lock indication from the synthesizer |
| phase_low | input | 1 | High when the output clocks are in their low phase |
| clk_en | output | NUM_CLK | Per-clock gate enables |
| vco_en | output | 1 | Synthesizer VCO enable |
| osc_en | output | 1 | Crystal oscillator enable |
| run_status | output | 1 | High only in the running state |

## Verification
The bench builds the block with a park wait of 2, a VCO-off wait of 3, an oscillator settle of 20, a lock settle of 10 and an 8-bit counter. With these values the shutdown and the whole cold restart fit in a few dozen cycles. The cycle windows of R9 and R10 can then be measured exactly. A power-down can be re-issued mid-way through the oscillator wait. The reference clock is stopped during the power-down so that the asynchronous oscillator release is observed with no clock edge present.

// File: rtl/clkpd_pkg.sv
// Package: shared state encoding for the clock power-down sequencer.
// Assumes: one state register owned by clkpd_fsm.
package clkpd_pkg;
    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_PARK      = 3'd1,
        ST_VCO_OFF   = 3'd2,
        ST_OSC_OFF   = 3'd3,
        ST_OSC_START = 3'd4,
        ST_LOCK_WAIT = 3'd5,
        ST_RELEASE   = 3'd6
    } pd_state_e;
endpackage

// File: rtl/clkpd_sync.sv
// Module: two-flop synchronizer for the active-low power-down request.
// Produces an active-high "power-down active" flag in the reference domain.
// Assumes: the request may change at any time relative to clk_ref.
module clkpd_sync (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic req_n,
    output logic pd_act
);
    logic s1_q, s2_q;

    // Purpose: two-stage capture of the raw request; reset to inactive.
    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else begin
            s1_q <= req_n;
            s2_q <= s1_q;
        end
    end

    assign pd_act = ~s2_q;
endmodule

// File: rtl/clkpd_timer.sv
// Module: down-counting wait timer shared by all sequencer states.
// Loads a value on request and reports done when it reaches zero.
// Assumes: the loader holds load for one cycle per wait.
module clkpd_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // Purpose: load on request, otherwise count down to zero and stay there.
    always_ff @(posedge clk_ref) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    // R9: a loaded count never rises by itself
    a_r9_count_monotonic: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !load |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/clkpd_gate_bank.sv
// Module: per-clock gate enable registers.
// Each enable is updated only when the output clocks are in their low phase,
// so that no pulse is shortened. Enables follow the group stop requests while
// running and are all forced low otherwise.
// Assumes: phase_low is synchronous to clk_ref.
module clkpd_gate_bank #(
    parameter int                NUM_CLK  = 5,
    parameter logic [NUM_CLK-1:0] CPU_MASK = 5'b00001,
    parameter logic [NUM_CLK-1:0] PCI_MASK = 5'b00010
) (
    input  logic               clk_ref,
    input  logic               rst_n,
    input  logic               run,
    input  logic               phase_low,
    input  logic               cpu_stop_n,
    input  logic               pci_stop_n,
    output logic [NUM_CLK-1:0] clk_en,
    output logic               all_off
);
    logic [NUM_CLK-1:0] target;
    logic [NUM_CLK-1:0] en_q;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CLK; gi++) begin : g_gate
            // Purpose: running value of one enable from its group masks.
            assign target[gi] = run
                & ~(CPU_MASK[gi] & ~cpu_stop_n)
                & ~(PCI_MASK[gi] & ~pci_stop_n);

            // Purpose: enable flop, updated only at a low-phase edge.
            always_ff @(posedge clk_ref) begin
                if (!rst_n)         en_q[gi] <= 1'b0;
                else if (phase_low) en_q[gi] <= target[gi];
            end
        end
    endgenerate

    assign clk_en  = en_q;
    assign all_off = (en_q == '0);

    // R3: enables hold unless the edge fell in the low phase
    a_r3_change_on_low_phase: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ($past(rst_n) && !$past(phase_low)) |-> $stable(en_q));
    // R5: once not running and a low phase has passed, all enables are zero
    a_r5_parked_when_stopped: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ($past(rst_n) && !$past(run) && $past(phase_low)) |-> (en_q == '0));
endmodule

// File: rtl/clkpd_fsm.sv
// Module: power-down sequencing state machine.
// Shutdown order: park clocks, VCOs off, oscillator off. Wake order:
// oscillator on (asynchronously), settle, VCOs on, wait for lock and settle,
// release clocks at a low-phase edge. Outputs are registered from next state.
// Assumes: pd_act comes from a synchronizer; pwrdn_req_n is the raw pin.
module clkpd_fsm
    import clkpd_pkg::*;
#(
    parameter int CNT_W           = 16,
    parameter int PARK_CYC        = 4,
    parameter int VCO_OFF_CYC     = 8,
    parameter int OSC_START_CYC   = 28000,
    parameter int LOCK_SETTLE_CYC = 1024
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             pwrdn_req_n,
    input  logic             pd_act,
    input  logic             vco_lock,
    input  logic             phase_low,
    input  logic             all_off,
    input  logic             tmr_done,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             run_status,
    output logic             vco_en,
    output logic             osc_en
);
    localparam logic [CNT_W-1:0] PARK_V = CNT_W'(PARK_CYC);
    localparam logic [CNT_W-1:0] VOFF_V = CNT_W'(VCO_OFF_CYC);
    localparam logic [CNT_W-1:0] OSC_V  = CNT_W'(OSC_START_CYC);
    localparam logic [CNT_W-1:0] LOCK_V = CNT_W'(LOCK_SETTLE_CYC);

    pd_state_e state_q, state_d;
    logic      run_q, vco_q, sleep_q, enter_sleep;

    // Purpose: next-state and timer-load decode.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_RUN: if (pd_act) begin
                state_d = ST_PARK;  tmr_load = 1'b1; tmr_val = PARK_V;
            end
            ST_PARK: if (tmr_done && all_off) begin
                state_d = ST_VCO_OFF; tmr_load = 1'b1; tmr_val = VOFF_V;
            end
            ST_VCO_OFF: if (tmr_done) state_d = ST_OSC_OFF;
            ST_OSC_OFF: if (!pd_act) begin
                state_d = ST_OSC_START; tmr_load = 1'b1; tmr_val = OSC_V;
            end
            ST_OSC_START: begin
                if (pd_act) begin
                    state_d = ST_VCO_OFF; tmr_load = 1'b1; tmr_val = VOFF_V;
                end else if (tmr_done) begin
                    state_d = ST_LOCK_WAIT; tmr_load = 1'b1; tmr_val = LOCK_V;
                end
            end
            ST_LOCK_WAIT: begin
                if (pd_act) begin
                    state_d = ST_VCO_OFF; tmr_load = 1'b1; tmr_val = VOFF_V;
                end else if (!vco_lock) begin
                    tmr_load = 1'b1; tmr_val = LOCK_V;
                end else if (tmr_done) begin
                    state_d = ST_RELEASE;
                end
            end
            ST_RELEASE: begin
                if (pd_act) begin
                    state_d = ST_PARK; tmr_load = 1'b1; tmr_val = PARK_V;
                end else if (phase_low) begin
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // Purpose: state register and registered run/VCO outputs.
    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            run_q   <= 1'b1;
            vco_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            run_q   <= (state_d == ST_RUN);
            vco_q   <= (state_d == ST_RUN) || (state_d == ST_PARK) ||
                       (state_d == ST_LOCK_WAIT) || (state_d == ST_RELEASE);
        end
    end

    assign enter_sleep = (state_q == ST_VCO_OFF) && (state_d == ST_OSC_OFF);

    // Purpose: oscillator-off flag, cleared asynchronously by the raw release.
    always_ff @(posedge clk_ref or posedge pwrdn_req_n) begin
        if (pwrdn_req_n)                  sleep_q <= 1'b0;
        else if (!rst_n)                  sleep_q <= 1'b0;
        else if (enter_sleep)             sleep_q <= 1'b1;
        else if (state_q != ST_OSC_OFF)   sleep_q <= 1'b0;
    end

    assign run_status = run_q;
    assign vco_en     = vco_q;
    assign osc_en     = ~sleep_q;

    // R4: leaving the running state needs a synchronized request
    a_r4_exit_on_sync: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $fell(run_q) |-> $past(pd_act));
    // R6: VCOs are off only with every clock parked
    a_r6_vco_off_parked: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !vco_q |-> all_off);
    // R7: oscillator is off only with the VCOs off
    a_r7_osc_after_vco: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !sleep_q || !vco_q);
    // R10: running resumes only with the VCOs and oscillator on
    a_r10_resume_locked: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ($past(rst_n) && $rose(run_q)) |-> ($past(vco_q) && !sleep_q));
endmodule

// File: rtl/clkpd_sequencer.sv
// Module: top of the clock power-down sequencer.
// Connects the request synchronizer, the wait timer, the state machine and
// the per-clock gate enables.
// Assumes: clk_ref is the reference clock, which may stop while power-down
// is in effect. The synthesizer is modelled by vco_en/osc_en/vco_lock/phase_low.
module clkpd_sequencer #(
    parameter int                 NUM_CLK         = 5,
    parameter logic [NUM_CLK-1:0] CPU_MASK        = 5'b00001,
    parameter logic [NUM_CLK-1:0] PCI_MASK        = 5'b00010,
    parameter int                 CNT_W           = 16,
    parameter int                 PARK_CYC        = 4,
    parameter int                 VCO_OFF_CYC     = 8,
    parameter int                 OSC_START_CYC   = 28000,
    parameter int                 LOCK_SETTLE_CYC = 1024
) (
    input  logic               clk_ref,
    input  logic               rst_n,
    input  logic               pwrdn_req_n,
    input  logic               cpu_stop_n,
    input  logic               pci_stop_n,
    input  logic               vco_lock,
    input  logic               phase_low,
    output logic [NUM_CLK-1:0] clk_en,
    output logic               vco_en,
    output logic               osc_en,
    output logic               run_status
);
    logic             pd_act, all_off, tmr_done, tmr_load;
    logic [CNT_W-1:0] tmr_val;

    clkpd_sync u_sync (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .req_n   (pwrdn_req_n),
        .pd_act  (pd_act)
    );

    clkpd_timer #(.CNT_W(CNT_W)) u_timer (
        .clk_ref  (clk_ref),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    clkpd_fsm #(
        .CNT_W           (CNT_W),
        .PARK_CYC        (PARK_CYC),
        .VCO_OFF_CYC     (VCO_OFF_CYC),
        .OSC_START_CYC   (OSC_START_CYC),
        .LOCK_SETTLE_CYC (LOCK_SETTLE_CYC)
    ) u_fsm (
        .clk_ref     (clk_ref),
        .rst_n       (rst_n),
        .pwrdn_req_n (pwrdn_req_n),
        .pd_act      (pd_act),
        .vco_lock    (vco_lock),
        .phase_low   (phase_low),
        .all_off     (all_off),
        .tmr_done    (tmr_done),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .run_status  (run_status),
        .vco_en      (vco_en),
        .osc_en      (osc_en)
    );

    clkpd_gate_bank #(
        .NUM_CLK  (NUM_CLK),
        .CPU_MASK (CPU_MASK),
        .PCI_MASK (PCI_MASK)
    ) u_gates (
        .clk_ref    (clk_ref),
        .rst_n      (rst_n),
        .run        (run_status),
        .phase_low  (phase_low),
        .cpu_stop_n (cpu_stop_n),
        .pci_stop_n (pci_stop_n),
        .clk_en     (clk_en),
        .all_off    (all_off)
    );
endmodule

// File: tb/clkpd_sequencer_bench.sv
module clkpd_sequencer_bench;
    localparam int PERIOD   = 10;
    localparam int PARK     = 2;
    localparam int VOFF     = 3;
    localparam int OSC      = 20;
    localparam int LOCK     = 10;
    localparam int LOCK_DLY = 6;
    localparam int NV       = 6;
    // {cpu_stop_n, pci_stop_n, expected clk_en[4:0]}
    localparam logic [6:0] VEC [NV] = '{
        7'b11_11111, 7'b01_11110, 7'b10_11101,
        7'b00_11100, 7'b01_11110, 7'b11_11111
    };

    logic clk = 1'b0, clk_run = 1'b1;
    logic rst_n = 1'b0, pd_n = 1'b1, cpu_n = 1'b1, pci_n = 1'b1;
    logic vco_lock = 1'b0, ph = 1'b0, ph_auto = 1'b1;
    logic [4:0] clk_en;
    logic vco_en, osc_en, run_status;
    int checks = 0, fails = 0, lk_cnt = 0;
    bit done_flag = 1'b0;

    clkpd_sequencer #(
        .CNT_W(8), .PARK_CYC(PARK), .VCO_OFF_CYC(VOFF),
        .OSC_START_CYC(OSC), .LOCK_SETTLE_CYC(LOCK)
    ) u_clkpd_sequencer (
        .clk_ref(clk), .rst_n(rst_n), .pwrdn_req_n(pd_n),
        .cpu_stop_n(cpu_n), .pci_stop_n(pci_n), .vco_lock(vco_lock),
        .phase_low(ph), .clk_en(clk_en), .vco_en(vco_en),
        .osc_en(osc_en), .run_status(run_status)
    );

    initial forever begin
        #(PERIOD/2);
        if (clk_run) clk = ~clk;
    end

    initial forever begin
        @(negedge clk);
        if (ph_auto) ph = ~ph;
    end

    // synthesizer lock model: lock LOCK_DLY cycles after VCO enable
    initial forever begin
        @(negedge clk);
        if (!vco_en) begin lk_cnt = 0; vco_lock = 1'b0; end
        else begin
            if (lk_cnt < LOCK_DLY) lk_cnt++;
            vco_lock = (lk_cnt >= LOCK_DLY);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(PERIOD*200000);
        if (!done_flag) begin
            fails++; checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        bit vco_low_seen, order_ok;
        logic [4:0] held;
        cyc(4);
        // R1: reset values
        chk(run_status == 1'b1, "R1 run_status", run_status, 1);
        chk(vco_en == 1'b1 && osc_en == 1'b1, "R1 vco/osc", {vco_en, osc_en}, 3);
        chk(clk_en == 5'd0, "R1 clk_en", clk_en, 0);
        rst_n = 1'b1;
        cyc(4);

        // R2: stop-request vector table
        for (int v = 0; v < NV; v++) begin
            cpu_n = VEC[v][6];
            pci_n = VEC[v][5];
            cyc(4);
            chk(clk_en == VEC[v][4:0], "R2 group gating", clk_en, VEC[v][4:0]);
        end

        // R3: no update while phase_low stays 0
        ph_auto = 1'b0; ph = 1'b0;
        held = clk_en;
        cpu_n = 1'b0;
        cyc(3);
        chk(clk_en == held, "R3 hold in high phase", clk_en, held);
        ph = 1'b1;
        cyc(1);
        chk(clk_en == 5'b11110, "R3 update at low phase", clk_en, 5'b11110);
        cpu_n = 1'b1;
        ph_auto = 1'b1;
        cyc(4);

        // R4: synchronized power-down entry
        pd_n = 1'b0;
        cyc(1);
        chk(run_status == 1'b1, "R4 not yet seen", run_status, 1);
        cyc(3);
        chk(run_status == 1'b0, "R4 entered", run_status, 0);

        // R5/R6/R7: ordered shutdown, stops ignored
        vco_low_seen = 1'b0; order_ok = 1'b1;
        for (int i = 0; i < 30; i++) begin
            cpu_n = i[0]; pci_n = i[1];
            @(negedge clk);
            if (!vco_en) vco_low_seen = 1'b1;
            if (!vco_en && clk_en != 5'd0) order_ok = 1'b0;
            if (!osc_en && !vco_low_seen) order_ok = 1'b0;
        end
        chk(clk_en == 5'd0, "R5 parked with stops toggling", clk_en, 0);
        chk(order_ok, "R6 clocks parked before VCO off", order_ok, 1);
        chk(vco_en == 1'b0 && osc_en == 1'b0, "R7 VCO then osc off", {vco_en, osc_en}, 0);
        cpu_n = 1'b1; pci_n = 1'b1;

        // R8: asynchronous oscillator release with no clock
        clk_run = 1'b0;
        #(PERIOD*5);
        pd_n = 1'b1;
        #1;
        chk(osc_en == 1'b1, "R8 async osc release", osc_en, 1);
        #(PERIOD*2);
        clk_run = 1'b1;

        // R9: oscillator settle before VCO enable
        n = 0;
        while (!vco_en && n < 200) begin @(negedge clk); n++; end
        chk(n >= OSC + 2 && n <= OSC + 6, "R9 VCO enable delay", n, OSC + 4);

        // R10: lock plus settle before release
        n = 0;
        while (!run_status && n < 200) begin @(negedge clk); n++; end
        chk(n >= LOCK_DLY + LOCK && n <= LOCK_DLY + LOCK + 8, "R10 release after lock", n, LOCK_DLY + LOCK + 2);
        cyc(4);
        chk(clk_en == 5'b11111, "R10 clocks resumed", clk_en, 5'b11111);

        // R11: re-request during oscillator settle
        pd_n = 1'b0;
        n = 0;
        while (osc_en && n < 200) begin @(negedge clk); n++; end
        pd_n = 1'b1;
        cyc(8);
        pd_n = 1'b0;
        order_ok = 1'b1;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (vco_en || run_status || clk_en != 5'd0) order_ok = 1'b0;
        end
        chk(order_ok, "R11 no release during abort", order_ok, 1);
        chk(osc_en == 1'b0, "R11 back to osc off", osc_en, 0);
        pd_n = 1'b1;
        n = 0;
        while (!run_status && n < 300) begin @(negedge clk); n++; end
        cyc(4);
        chk(run_status == 1'b1 && clk_en == 5'b11111, "R11 full wake after abort", clk_en, 5'b11111);

        done_flag = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule